// File: doc/BRIEF.md
# Coprocessor Squash Filter with Dual Tags

This block stands between a scalar control processor and a slower multi-cycle coprocessor. The scalar side can run ahead of the coprocessor, so several coprocessor instructions may be waiting when a branch turns out to be mispredicted. The block stamps each accepted coprocessor instruction with two tags: the count of branches dispatched before it and the current misprediction epoch. It keeps the tagged instructions in a small ordered queue. For the entry at the head of the queue, it decides whether the coprocessor should execute it or drop it.

A kill notice carries the branch count of the mispredicted branch and the new epoch value. An entry with the current epoch always executes. An entry with an older epoch executes only when it was dispatched no later than the recorded branch, which means its branch count is at or before the recorded count in 8-bit modular order. This lets instructions issued before the bad branch finish even though the epoch has already moved on. The branch counter is 8 bits wide and wraps. No more than 127 branches may be in flight at once.

Both sides of the queue use valid/ready. A producer may hold `in_valid` with stable data until `in_ready` is high, and the entry is taken on the clock edge where both are high. `in_ready` is low only while the queue is full. The consumer sees the head entry while `out_valid` is high, and the head entry with its flag stays stable until `out_ready` is high at a clock edge. A dropped entry still completes one handshake with `out_exec` low, and the consumer must give it no architectural effect. `br_disp`, the kill inputs and `cur_branch_count` are plain control pins.

Top module: `cop_squash_filter`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, `cur_branch_count` is 0 and the epoch is 0.
- R2: Each cycle with `br_disp` high adds 1 to the 8-bit branch counter from the next cycle on. The counter wraps from 255 to 0 and is visible on `cur_branch_count`.
- R3: An accepted instruction is tagged with the branch count and epoch as they stood before its accept edge. A branch dispatched or a kill given in the same cycle affects only later instructions. The head's branch tag appears on `out_branch_tag`.
- R4: Entries leave in arrival order. `in_ready` is low exactly when DEPTH entries are held, and an offer made while full is not taken. The head data, tag and flag stay stable while `out_valid` is high and `out_ready` is low.
- R5: A head entry whose epoch tag equals the current epoch is presented with `out_exec` = 1.
- R6: A head entry with an older epoch and branch tag b is presented with `out_exec` = 1 when (recorded − b) mod 256 is below 128.
- R7: Every other head entry is presented with `out_exec` = 0, and it still leaves the queue on a handshake.
- R8: A kill sets the current epoch to `kill_epoch` from the next cycle. When no queued entry carries an epoch other than the current one, the kill also records `kill_branch`.
- R9: When queued entries with an older epoch are present, a kill replaces the recorded count only if `kill_branch` is strictly older: (recorded − kill_branch) mod 256 is in 1..127.
- R10: In the cycle a kill is given, the head decision still uses the state from before the kill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_disp | input | 1 | A branch is dispatched this cycle |
| in_valid | input | 1 | Coprocessor instruction offered |
| in_ready | output | 1 | Queue can take an instruction |
| in_data | input | DATA_W | Instruction payload |
| kill_valid | input | 1 | Misprediction notice |
| kill_branch | input | 8 | Branch count of the mispredicted branch |
| kill_epoch | input | EPOCH_W | New misprediction epoch |
| out_valid | output | 1 | Head entry presented |
| out_ready | input | 1 | Consumer takes the head entry |
| out_data | output | DATA_W | Head payload |
| out_exec | output | 1 | 1 = execute head, 0 = drop |
| out_branch_tag | output | 8 | Branch tag of head entry |
| cur_branch_count | output | 8 | Tag the next branch receives |

## Verification
The bench places entries on both sides of a mispredicted branch. It expects the older ones to run and the younger ones to be dropped, which a single-epoch design would fail by dropping everything. It drives the branch counter across the 255-to-0 wrap, where a plain magnitude compare would keep a younger entry. It sends two kills in both age orders while stale entries are queued, which catches a design that always overwrites, or never overwrites, the recorded count. It also lines up a branch or kill in the same cycle as an accept or a pop, where a tag or decision taken one cycle late would mark an entry with the wrong epoch.

// File: rtl/cop_sqf_pkg.sv
package cop_sqf_pkg;

  localparam int BR_W = 8;

  typedef logic [BR_W-1:0] brcnt_t;

  // b lies at or before r in modular order (distance below half range)
  function automatic logic br_at_or_before(brcnt_t b, brcnt_t r);
    brcnt_t d;
    d = r - b;
    return !d[BR_W-1];
  endfunction

  // a lies strictly before r in modular order
  function automatic logic br_strictly_before(brcnt_t a, brcnt_t r);
    brcnt_t d;
    d = r - a;
    return (d != '0) && !d[BR_W-1];
  endfunction

endpackage

// File: rtl/cop_sqf_tagger.sv
module cop_sqf_tagger
  import cop_sqf_pkg::*;
#(
  parameter int EPOCH_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               br_disp,
  input  logic               kill_valid,
  input  logic [EPOCH_W-1:0] kill_epoch,
  output brcnt_t             br_count,
  output logic [EPOCH_W-1:0] epoch
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br_count <= '0;
      epoch    <= '0;
    end else begin
      if (br_disp)    br_count <= br_count + 1'b1;
      if (kill_valid) epoch    <= kill_epoch;
    end
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    br_disp |=> (br_count == brcnt_t'($past(br_count) + 1'b1)));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !br_disp |=> $stable(br_count));

  assert_epoch_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kill_valid |=> (epoch == $past(kill_epoch)));

endmodule

// File: rtl/cop_sqf_queue.sv
module cop_sqf_queue
  import cop_sqf_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 8,
  parameter int EPOCH_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [DATA_W-1:0]  push_data,
  input  brcnt_t             push_br,
  input  logic [EPOCH_W-1:0] push_ep,
  input  logic               pop,
  input  logic [EPOCH_W-1:0] cur_epoch,
  output logic               empty,
  output logic               full,
  output logic [DATA_W-1:0]  head_data,
  output brcnt_t             head_br,
  output logic [EPOCH_W-1:0] head_ep,
  output logic               stale_any
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0]  slot_data [DEPTH];
  brcnt_t             slot_br   [DEPTH];
  logic [EPOCH_W-1:0] slot_ep   [DEPTH];
  logic [DEPTH-1:0]   occ;
  logic [DEPTH-1:0]   stale_vec;
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   fill;

  assign empty = (fill == '0);
  assign full  = (fill == CNT_W'(DEPTH));

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [PTR_W-1:0] IDX = PTR_W'(i);

    always_ff @(posedge clk) begin
      if (push && wr_ptr == IDX) begin
        slot_data[i] <= push_data;
        slot_br[i]   <= push_br;
        slot_ep[i]   <= push_ep;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                     occ[i] <= 1'b0;
      else if (push && wr_ptr == IDX) occ[i] <= 1'b1;
      else if (pop && rd_ptr == IDX)  occ[i] <= 1'b0;
    end

    assign stale_vec[i] = occ[i] && (slot_ep[i] != cur_epoch);
  end

  assign stale_any = |stale_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign head_data = slot_data[rd_ptr];
  assign head_br   = slot_br[rd_ptr];
  assign head_ep   = slot_ep[rd_ptr];

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  assert_no_push_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  assert_occ_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ) == int'(fill));

  assert_head_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> (!empty && $stable(head_data) && $stable(head_br)));

endmodule

// File: rtl/cop_sqf_judge.sv
module cop_sqf_judge
  import cop_sqf_pkg::*;
#(
  parameter int EPOCH_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EPOCH_W-1:0] cur_epoch,
  input  logic [EPOCH_W-1:0] head_ep,
  input  brcnt_t             head_br,
  input  logic               kill_valid,
  input  brcnt_t             kill_branch,
  input  logic               stale_any,
  output logic               exec
);

  brcnt_t rec_branch;
  logic   same_epoch;
  logic   before_rec;
  logic   take_kill;

  assign same_epoch = (head_ep == cur_epoch);
  assign before_rec = br_at_or_before(head_br, rec_branch);
  assign exec       = same_epoch || before_rec;

  // keep the oldest bound while stale entries still depend on it
  assign take_kill = kill_valid &&
                     (!stale_any || br_strictly_before(kill_branch, rec_branch));

  always_ff @(posedge clk) begin
    if (!rst_n)         rec_branch <= '0;
    else if (take_kill) rec_branch <= kill_branch;
  end

  assert_same_epoch_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (head_ep == cur_epoch) |-> exec);

  assert_rec_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_valid && stale_any && !br_strictly_before(kill_branch, rec_branch))
      |=> $stable(rec_branch));

  assert_rec_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_valid && !stale_any) |=> (rec_branch == $past(kill_branch)));

endmodule

// File: rtl/cop_squash_filter.sv
module cop_squash_filter
  import cop_sqf_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 8,
  parameter int EPOCH_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               br_disp,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               kill_valid,
  input  logic [BR_W-1:0]    kill_branch,
  input  logic [EPOCH_W-1:0] kill_epoch,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_exec,
  output logic [BR_W-1:0]    out_branch_tag,
  output logic [BR_W-1:0]    cur_branch_count
);

  brcnt_t             br_count;
  logic [EPOCH_W-1:0] epoch;
  logic               q_empty, q_full, q_stale;
  logic [EPOCH_W-1:0] head_ep;
  brcnt_t             head_br;
  logic               judge_exec;
  logic               push, pop;

  assign in_ready = !q_full;
  assign push     = in_valid && in_ready;
  assign out_valid = !q_empty;
  assign pop      = out_valid && out_ready;

  cop_sqf_tagger #(.EPOCH_W(EPOCH_W)) u_tagger (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_disp    (br_disp),
    .kill_valid (kill_valid),
    .kill_epoch (kill_epoch),
    .br_count   (br_count),
    .epoch      (epoch)
  );

  cop_sqf_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH), .EPOCH_W(EPOCH_W)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (in_data),
    .push_br   (br_count),
    .push_ep   (epoch),
    .pop       (pop),
    .cur_epoch (epoch),
    .empty     (q_empty),
    .full      (q_full),
    .head_data (out_data),
    .head_br   (head_br),
    .head_ep   (head_ep),
    .stale_any (q_stale)
  );

  cop_sqf_judge #(.EPOCH_W(EPOCH_W)) u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur_epoch   (epoch),
    .head_ep     (head_ep),
    .head_br     (head_br),
    .kill_valid  (kill_valid),
    .kill_branch (kill_branch),
    .stale_any   (q_stale),
    .exec        (judge_exec)
  );

  assign out_exec         = out_valid && judge_exec;
  assign out_branch_tag   = head_br;
  assign cur_branch_count = br_count;

  assert_exec_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_exec |-> out_valid);

  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !kill_valid) |=> (out_valid && $stable(out_exec)));

endmodule

// File: tb/test_cop_squash_filter.sv
`timescale 1ns/1ps
module test_cop_squash_filter;

  localparam int DW = 16;
  localparam int DEPTH = 8;
  localparam int EW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          br_disp = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          kill_valid = 1'b0;
  logic [7:0]    kill_branch = '0;
  logic [EW-1:0] kill_epoch = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic          out_exec;
  logic [7:0]    out_branch_tag;
  logic [7:0]    cur_branch_count;

  int checks = 0;
  int failures = 0;
  logic [7:0]    cnt = '0;
  logic [EW-1:0] ep = '0;

  always #2.5 clk = ~clk;

  cop_squash_filter #(.DATA_W(DW), .DEPTH(DEPTH), .EPOCH_W(EW)) i_cop_squash_filter (
    .clk(clk), .rst_n(rst_n), .br_disp(br_disp),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .kill_valid(kill_valid), .kill_branch(kill_branch), .kill_epoch(kill_epoch),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_exec(out_exec), .out_branch_tag(out_branch_tag),
    .cur_branch_count(cur_branch_count)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] d, input logic br);
    in_valid = 1'b1; in_data = d; br_disp = br;
    @(negedge clk);
    in_valid = 1'b0; br_disp = 1'b0;
    if (br) cnt = cnt + 1'b1;
  endtask

  task automatic branch();
    br_disp = 1'b1;
    @(negedge clk);
    br_disp = 1'b0;
    cnt = cnt + 1'b1;
  endtask

  task automatic kill(input logic [7:0] kb);
    ep = ep + 1'b1;
    kill_valid = 1'b1; kill_branch = kb; kill_epoch = ep;
    @(negedge clk);
    kill_valid = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [DW-1:0] d,
                            input logic [7:0] tag, input logic ex);
    chk(req, "out_valid", out_valid, 1);
    chk(req, "out_data", out_data, d);
    chk(req, "out_branch_tag", out_branch_tag, tag);
    chk(req, "out_exec", out_exec, ex);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  // R1: state after reset
  task automatic t_reset();
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "cur_branch_count", cur_branch_count, 0);
  endtask

  // R2: counter steps once per branch
  task automatic t_counter();
    branch(); branch(); branch();
    chk("R2", "cur_branch_count", cur_branch_count, cnt);
    chk("R2", "count after three", cur_branch_count, 3);
  endtask

  // R3 / R5: tags on accept, same-cycle branch tags pre-increment
  task automatic t_same_epoch();
    logic [7:0] c;
    c = cnt;
    push(16'hA001, 1'b1);
    push(16'hA002, 1'b0);
    pop_expect("R3", 16'hA001, c, 1'b1);
    pop_expect("R5", 16'hA002, c + 8'd1, 1'b1);
  endtask

  // R6 / R7 / R8: older entries kept, wrong-path entries dropped
  task automatic t_mispredict();
    logic [7:0] c;
    c = cnt;
    push(16'hB001, 1'b0);
    branch();
    push(16'hB002, 1'b0);
    branch();
    push(16'hB003, 1'b0);
    kill(c);
    push(16'hB004, 1'b0);
    pop_expect("R6", 16'hB001, c, 1'b1);
    pop_expect("R7", 16'hB002, c + 8'd1, 1'b0);
    pop_expect("R7", 16'hB003, c + 8'd2, 1'b0);
    pop_expect("R8", 16'hB004, c + 8'd2, 1'b1);
  endtask

  // R3 / R8: an accept in the kill cycle gets the old epoch
  task automatic t_kill_same_accept();
    logic [7:0] c;
    c = cnt;
    ep = ep + 1'b1;
    in_valid = 1'b1; in_data = 16'hC001;
    kill_valid = 1'b1; kill_branch = c - 8'd1; kill_epoch = ep;
    @(negedge clk);
    in_valid = 1'b0; kill_valid = 1'b0;
    pop_expect("R3", 16'hC001, c, 1'b0);
  endtask

  // R9: second kill with stale entries queued, both age orders
  task automatic t_second_kill();
    logic [7:0] c;
    c = cnt;
    push(16'hD001, 1'b0);
    branch();
    push(16'hD002, 1'b0);
    branch();
    push(16'hD003, 1'b0);
    kill(c + 8'd1);
    kill(c);
    pop_expect("R9", 16'hD001, c, 1'b1);
    pop_expect("R9", 16'hD002, c + 8'd1, 1'b0);
    pop_expect("R9", 16'hD003, c + 8'd2, 1'b0);
    c = cnt;
    push(16'hD011, 1'b0);
    branch();
    push(16'hD012, 1'b0);
    kill(c);
    kill(c + 8'd1);
    pop_expect("R9", 16'hD011, c, 1'b1);
    pop_expect("R9", 16'hD012, c + 8'd1, 1'b0);
  endtask

  // R2 / R6: counter wrap and modular compare
  task automatic t_wrap();
    while (cnt != 8'd254) branch();
    push(16'hE001, 1'b0);
    branch();
    push(16'hE002, 1'b0);
    branch();
    chk("R2", "wrapped count", cur_branch_count, 0);
    push(16'hE003, 1'b0);
    kill(8'd255);
    pop_expect("R6", 16'hE001, 8'd254, 1'b1);
    pop_expect("R6", 16'hE002, 8'd255, 1'b1);
    pop_expect("R7", 16'hE003, 8'd0, 1'b0);
  endtask

  // R4: fill, refuse, hold, drain in order
  task automatic t_backpressure();
    for (int i = 0; i < DEPTH; i++) push(16'h0100 + 16'(i), 1'b0);
    chk("R4", "in_ready full", in_ready, 0);
    in_valid = 1'b1; in_data = 16'hDEAD;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4", "head held", out_data, 16'h0100);
    chk("R4", "exec held", out_exec, 1);
    for (int i = 0; i < DEPTH; i++) pop_expect("R4", 16'h0100 + 16'(i), cnt, 1'b1);
    chk("R4", "drained out_valid", out_valid, 0);
  endtask

  // R10: kill in the pop cycle does not change that decision
  task automatic t_kill_at_pop();
    logic [7:0] c;
    c = cnt;
    push(16'hF001, 1'b0);
    ep = ep + 1'b1;
    kill_valid = 1'b1; kill_branch = c - 8'd1; kill_epoch = ep;
    out_ready = 1'b1;
    #1;
    chk("R10", "out_exec in kill cycle", out_exec, 1);
    @(negedge clk);
    kill_valid = 1'b0; out_ready = 1'b0;
    chk("R10", "popped", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_counter();
    t_same_epoch();
    t_mispredict();
    t_kill_same_accept();
    t_second_kill();
    t_wrap();
    t_backpressure();
    t_kill_at_pop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule